// File: doc/BRIEF.md
# Tile Configuration Address Decoder

This block is the configuration front end of one tile in a reconfigurable array. A shared configuration bus sends 32-bit addresses and 32-bit data to every tile. Each tile compares the identifier field of the address with its own 16-bit identifier, which arrives on an input port. Only accesses that match go further. A feature index then picks one of the tile's sub-blocks, and a register index picks a register inside that sub-block. The sub-blocks are the connection boxes, the switch box and the core.

The block holds the configuration registers of all features and drives their contents out to the routing and compute logic. That logic is not part of this block. The default build has two connection boxes, then a switch box with four registers, then a core with two registers. Writes are single-cycle pulses. A read strobe returns the addressed register, zero-extended, on a registered read-data output one cycle later.

Top module: `tile_cfg_front`

## Requirements
- R1: The address carries the tile identifier in bits [15:0], the feature index in bits [23:16] and the register index in bits [31:24]. Feature indices follow the fixed order of the feature list: 0 and 1 are the connection boxes, 2 is the switch box and 3 is the core.
- R2: A write pulse with a matching identifier and an existing feature and register updates that one register only. The new value is visible on the configuration outputs after the next clock edge.
- R3: A write whose identifier field differs from `tile_id_i` leaves every configuration register unchanged.
- R4: A write to a feature index of 4 or more, or to a register index the feature does not have, leaves every configuration register unchanged.
- R5: A register narrower than 32 bits keeps only the low bits of the write data. Connection box selects keep 4 bits. Switch box registers at even indices keep 2 bits and those at odd indices keep 1 bit. Core registers keep all 32 bits.
- R6: A read pulse to an existing register puts that register's value, zero-extended to 32 bits, on `cfg_rdata_o` one cycle later.
- R7: A read with a mismatched identifier, a missing feature or a missing register index returns zero.
- R8: `cfg_rdata_o` holds its value in every cycle without a read pulse, whatever the address does.
- R9: Reset sets each connection box select to 9 and every switch box register, core register and `cfg_rdata_o` to 0.
- R10: The identifier is compared against the live value of `tile_id_i`. After that port changes, only addresses that carry the new value take effect.
- R11: A read and a write to the same register in the same cycle return the value the register held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tile_id_i | input | 16 | This tile's identifier |
| cfg_addr_i | input | 32 | Configuration address (register, feature, identifier fields) |
| cfg_wdata_i | input | 32 | Configuration write data |
| cfg_we_i | input | 1 | Single-cycle write pulse |
| cfg_re_i | input | 1 | Single-cycle read pulse |
| cfg_rdata_o | output | 32 | Registered read data |
| cb_sel_o | output | 8 | Connection box selects, 4 bits per box, box 0 in the low bits |
| sb_cfg_o | output | 8 | Switch box registers, 2 bits each, register 0 lowest (odd entries use bit 0 only) |
| core_cfg_o | output | 64 | Core registers, 32 bits each, register 0 lowest |

## Verification
The assertions assume that `tile_id_i` is steady over any cycle in which a strobe is high. They also assume that no write pulse lands in the cycle after a mismatched or out-of-range write, because a stability check spans both cycles. The bench drives all inputs on the falling edge and lowers each strobe after one cycle. It changes the tile identifier only while both strobes are low. It samples outputs on the falling edge after the edge that the single register stage acts on.

// File: rtl/tile_cfg_pkg.sv
package tile_cfg_pkg;

    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;
    localparam int ID_W   = 16;
    localparam int IDX_W  = 8;

    // Address layout, most significant field first.
    typedef struct packed {
        logic [IDX_W-1:0] reg_idx;
        logic [IDX_W-1:0] feat_idx;
        logic [ID_W-1:0]  tile_id;
    } cfg_addr_t;

    // Decoded access handed from the decoder to the banks and read path.
    typedef struct packed {
        logic             id_ok;
        logic [IDX_W-1:0] feat;
        logic [IDX_W-1:0] regi;
    } cfg_sel_t;

    function automatic int reg_width(input int idx, input int even_w, input int odd_w);
        return (idx % 2 == 0) ? even_w : odd_w;
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/tile_cfg_addr_dec.sv
module tile_cfg_addr_dec
    import tile_cfg_pkg::*;
#(
    parameter int NUM_FEAT = 4
) (
    input  logic [ID_W-1:0]     tile_id_i,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic                we_i,
    output logic [NUM_FEAT-1:0] feat_we_o,
    output cfg_sel_t            sel_o
);

    cfg_addr_t fields;
    logic      id_match;

    assign fields   = cfg_addr_t'(addr_i);
    assign id_match = (fields.tile_id == tile_id_i);

    assign sel_o.id_ok = id_match;
    assign sel_o.feat  = fields.feat_idx;
    assign sel_o.regi  = fields.reg_idx;

    for (genvar f = 0; f < NUM_FEAT; f++) begin : g_we
        assign feat_we_o[f] = we_i && id_match && (fields.feat_idx == IDX_W'(f));
    end

endmodule

// File: rtl/tile_cfg_regbank.sv
module tile_cfg_regbank
    import tile_cfg_pkg::*;
#(
    parameter int              NREGS   = 2,
    parameter int              EVEN_W  = 32,
    parameter int              ODD_W   = 32,
    parameter logic [DATA_W-1:0] RST_VAL = '0
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    we_i,
    input  logic [IDX_W-1:0]        reg_idx_i,
    input  logic [DATA_W-1:0]       wdata_i,
    output logic [NREGS*DATA_W-1:0] regs_o
);

    for (genvar i = 0; i < NREGS; i++) begin : g_reg
        localparam int W = reg_width(i, EVEN_W, ODD_W);
        logic [W-1:0] q;

        always_ff @(posedge clk) begin
            if (rst) begin
                q <= RST_VAL[W-1:0];
            end else if (we_i && (reg_idx_i == IDX_W'(i))) begin
                q <= wdata_i[W-1:0];
            end
        end

        assign regs_o[i*DATA_W +: DATA_W] = DATA_W'(q);
    end

endmodule

// File: rtl/tile_cfg_rd_mux.sv
module tile_cfg_rd_mux
    import tile_cfg_pkg::*;
#(
    parameter int NUM_FEAT = 4,
    parameter int MAX_REGS = 4
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                re_i,
    input  cfg_sel_t                            sel_i,
    input  logic [NUM_FEAT*MAX_REGS*DATA_W-1:0] regs_i,
    output logic [DATA_W-1:0]                   rdata_o
);

    logic [DATA_W-1:0] pick;

    // Slots a feature does not have are zero-filled, so a miss reads 0.
    always_comb begin
        pick = '0;
        for (int f = 0; f < NUM_FEAT; f++) begin
            for (int r = 0; r < MAX_REGS; r++) begin
                if (sel_i.id_ok && (sel_i.feat == IDX_W'(f)) && (sel_i.regi == IDX_W'(r))) begin
                    pick = regs_i[(f*MAX_REGS + r)*DATA_W +: DATA_W];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_o <= '0;
        end else if (re_i) begin
            rdata_o <= pick;
        end
    end

endmodule

// File: rtl/tile_cfg_front.sv
module tile_cfg_front
    import tile_cfg_pkg::*;
#(
    parameter int NUM_CB    = 2,
    parameter int CB_W      = 4,
    parameter int CB_RST    = 9,
    parameter int SB_REGS   = 4,
    parameter int CORE_REGS = 2
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [15:0]                 tile_id_i,
    input  logic [31:0]                 cfg_addr_i,
    input  logic [31:0]                 cfg_wdata_i,
    input  logic                        cfg_we_i,
    input  logic                        cfg_re_i,
    output logic [31:0]                 cfg_rdata_o,
    output logic [NUM_CB*CB_W-1:0]      cb_sel_o,
    output logic [SB_REGS*2-1:0]        sb_cfg_o,
    output logic [CORE_REGS*32-1:0]     core_cfg_o
);

    localparam int NUM_FEAT  = NUM_CB + 2;
    localparam int SB_FEAT   = NUM_CB;
    localparam int CORE_FEAT = NUM_CB + 1;
    localparam int MAX_REGS  = max3(1, SB_REGS, CORE_REGS);

    logic [NUM_FEAT-1:0]                 feat_we;
    cfg_sel_t                            sel;
    logic [NUM_CB-1:0][DATA_W-1:0]       cb_word;
    logic [SB_REGS*DATA_W-1:0]           sb_flat;
    logic [CORE_REGS*DATA_W-1:0]         core_flat;
    logic [NUM_FEAT*MAX_REGS*DATA_W-1:0] all_regs;

    tile_cfg_addr_dec #(.NUM_FEAT(NUM_FEAT)) u_dec (
        .tile_id_i (tile_id_i),
        .addr_i    (cfg_addr_i),
        .we_i      (cfg_we_i),
        .feat_we_o (feat_we),
        .sel_o     (sel)
    );

    for (genvar c = 0; c < NUM_CB; c++) begin : g_cb
        tile_cfg_regbank #(
            .NREGS   (1),
            .EVEN_W  (CB_W),
            .ODD_W   (CB_W),
            .RST_VAL (DATA_W'(CB_RST))
        ) u_cb (
            .clk       (clk),
            .rst       (rst),
            .we_i      (feat_we[c]),
            .reg_idx_i (sel.regi),
            .wdata_i   (cfg_wdata_i),
            .regs_o    (cb_word[c])
        );
        assign cb_sel_o[c*CB_W +: CB_W] = cb_word[c][CB_W-1:0];
    end

    tile_cfg_regbank #(
        .NREGS   (SB_REGS),
        .EVEN_W  (2),
        .ODD_W   (1),
        .RST_VAL ('0)
    ) u_sb (
        .clk       (clk),
        .rst       (rst),
        .we_i      (feat_we[SB_FEAT]),
        .reg_idx_i (sel.regi),
        .wdata_i   (cfg_wdata_i),
        .regs_o    (sb_flat)
    );

    for (genvar s = 0; s < SB_REGS; s++) begin : g_sb_out
        assign sb_cfg_o[s*2 +: 2] = sb_flat[s*DATA_W +: 2];
    end

    tile_cfg_regbank #(
        .NREGS   (CORE_REGS),
        .EVEN_W  (DATA_W),
        .ODD_W   (DATA_W),
        .RST_VAL ('0)
    ) u_core (
        .clk       (clk),
        .rst       (rst),
        .we_i      (feat_we[CORE_FEAT]),
        .reg_idx_i (sel.regi),
        .wdata_i   (cfg_wdata_i),
        .regs_o    (core_flat)
    );

    assign core_cfg_o = core_flat;

    // Pack every feature into a fixed grid of MAX_REGS slots.
    always_comb begin
        all_regs = '0;
        for (int c = 0; c < NUM_CB; c++) begin
            all_regs[(c*MAX_REGS)*DATA_W +: DATA_W] = cb_word[c];
        end
        for (int r = 0; r < SB_REGS; r++) begin
            all_regs[(SB_FEAT*MAX_REGS + r)*DATA_W +: DATA_W] = sb_flat[r*DATA_W +: DATA_W];
        end
        for (int r = 0; r < CORE_REGS; r++) begin
            all_regs[(CORE_FEAT*MAX_REGS + r)*DATA_W +: DATA_W] = core_flat[r*DATA_W +: DATA_W];
        end
    end

    tile_cfg_rd_mux #(
        .NUM_FEAT (NUM_FEAT),
        .MAX_REGS (MAX_REGS)
    ) u_rd (
        .clk     (clk),
        .rst     (rst),
        .re_i    (cfg_re_i),
        .sel_i   (sel),
        .regs_i  (all_regs),
        .rdata_o (cfg_rdata_o)
    );

endmodule

// File: rtl/tile_cfg_front_chk.sv
module tile_cfg_front_chk #(
    parameter int NUM_CB    = 2,
    parameter int CB_W      = 4,
    parameter int SB_REGS   = 4,
    parameter int CORE_REGS = 2
) (
    input logic                    clk,
    input logic                    rst,
    input logic [15:0]             tile_id_i,
    input logic [31:0]             cfg_addr_i,
    input logic                    cfg_we_i,
    input logic                    cfg_re_i,
    input logic [31:0]             cfg_rdata_o,
    input logic [NUM_CB*CB_W-1:0]  cb_sel_o,
    input logic [SB_REGS*2-1:0]    sb_cfg_o,
    input logic [CORE_REGS*32-1:0] core_cfg_o
);

    localparam int NUM_FEAT = NUM_CB + 2;

    logic id_miss;
    logic feat_miss;
    assign id_miss   = (cfg_addr_i[15:0] != tile_id_i);
    assign feat_miss = (cfg_addr_i[23:16] >= 8'(NUM_FEAT));

    // R3: a write for another tile leaves all configuration untouched
    a_r3_foreign_write_ignored: assert property (@(posedge clk) disable iff (rst)
        (cfg_we_i && id_miss) |=> ($stable(cb_sel_o) && $stable(sb_cfg_o) && $stable(core_cfg_o)));

    // R4: a write to a missing feature leaves all configuration untouched
    a_r4_missing_feature_ignored: assert property (@(posedge clk) disable iff (rst)
        (cfg_we_i && feat_miss) |=> ($stable(cb_sel_o) && $stable(sb_cfg_o) && $stable(core_cfg_o)));

    // R2: configuration only moves after a write pulse
    a_r2_no_write_no_change: assert property (@(posedge clk) disable iff (rst)
        !cfg_we_i |=> ($stable(cb_sel_o) && $stable(sb_cfg_o) && $stable(core_cfg_o)));

    // R7: a read for another tile returns zero
    a_r7_foreign_read_zero: assert property (@(posedge clk) disable iff (rst)
        (cfg_re_i && id_miss) |=> (cfg_rdata_o == 32'h0));

    // R7: a read of a missing feature returns zero
    a_r7_missing_feature_zero: assert property (@(posedge clk) disable iff (rst)
        (cfg_re_i && feat_miss) |=> (cfg_rdata_o == 32'h0));

    // R8: read data holds without a read pulse
    a_r8_rdata_holds: assert property (@(posedge clk) disable iff (rst)
        !cfg_re_i |=> $stable(cfg_rdata_o));

endmodule

bind tile_cfg_front tile_cfg_front_chk #(
    .NUM_CB    (NUM_CB),
    .CB_W      (CB_W),
    .SB_REGS   (SB_REGS),
    .CORE_REGS (CORE_REGS)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .tile_id_i   (tile_id_i),
    .cfg_addr_i  (cfg_addr_i),
    .cfg_we_i    (cfg_we_i),
    .cfg_re_i    (cfg_re_i),
    .cfg_rdata_o (cfg_rdata_o),
    .cb_sel_o    (cb_sel_o),
    .sb_cfg_o    (sb_cfg_o),
    .core_cfg_o  (core_cfg_o)
);

// File: tb/tile_cfg_front_tb_top.sv
module tile_cfg_front_tb_top;

    localparam logic [15:0] TID  = 16'hA5C3;
    localparam logic [15:0] TID2 = 16'h0042;
    localparam int          NVEC = 8;

    // {address, write data, expected read-back}
    localparam logic [95:0] VEC [NVEC] = '{
        {8'd0, 8'd0, TID, 32'h0000_0007, 32'h0000_0007},   // cb0 select
        {8'd0, 8'd1, TID, 32'hFFFF_FFF3, 32'h0000_0003},   // cb1 select, 4 bits kept
        {8'd0, 8'd2, TID, 32'hFFFF_FFFE, 32'h0000_0002},   // sb even, 2 bits kept
        {8'd1, 8'd2, TID, 32'h0000_0003, 32'h0000_0001},   // sb odd, 1 bit kept
        {8'd2, 8'd2, TID, 32'h0000_0001, 32'h0000_0001},
        {8'd3, 8'd2, TID, 32'h0000_0002, 32'h0000_0000},
        {8'd0, 8'd3, TID, 32'hDEAD_BEEF, 32'hDEAD_BEEF},   // core full width
        {8'd1, 8'd3, TID, 32'h1234_5678, 32'h1234_5678}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] tile_id_i = TID;
    logic [31:0] cfg_addr_i = '0;
    logic [31:0] cfg_wdata_i = '0;
    logic        cfg_we_i = 1'b0;
    logic        cfg_re_i = 1'b0;
    logic [31:0] cfg_rdata_o;
    logic [7:0]  cb_sel_o;
    logic [7:0]  sb_cfg_o;
    logic [63:0] core_cfg_o;

    int n_checks = 0;
    int n_fails  = 0;
    logic done = 1'b0;

    always #2.5 clk = ~clk;

    tile_cfg_front dut_i (
        .clk         (clk),
        .rst         (rst),
        .tile_id_i   (tile_id_i),
        .cfg_addr_i  (cfg_addr_i),
        .cfg_wdata_i (cfg_wdata_i),
        .cfg_we_i    (cfg_we_i),
        .cfg_re_i    (cfg_re_i),
        .cfg_rdata_o (cfg_rdata_o),
        .cb_sel_o    (cb_sel_o),
        .sb_cfg_o    (sb_cfg_o),
        .core_cfg_o  (core_cfg_o)
    );

    function automatic logic [31:0] mk(input logic [7:0] r, input logic [7:0] f, input logic [15:0] id);
        return {r, f, id};
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] a, input logic [31:0] d);
        cfg_addr_i  = a;
        cfg_wdata_i = d;
        cfg_we_i    = 1'b1;
        @(negedge clk);
        cfg_we_i    = 1'b0;
        @(negedge clk);
    endtask

    task automatic rd(input logic [31:0] a);
        cfg_addr_i = a;
        cfg_re_i   = 1'b1;
        @(negedge clk);
        cfg_re_i   = 1'b0;
    endtask

    task automatic summary;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R9: reset values
        check("R9 cb reset", 64'(cb_sel_o), 64'h99);
        check("R9 sb reset", 64'(sb_cfg_o), 64'h0);
        check("R9 core reset", core_cfg_o, 64'h0);
        check("R9 rdata reset", 64'(cfg_rdata_o), 64'h0);
        rd(mk(8'd0, 8'd0, TID));
        check("R9 R6 cb0 reset readback", 64'(cfg_rdata_o), 64'h9);

        // R1 R2 R5 R6: table walk, write all then read each back
        for (int i = 0; i < NVEC; i++) begin
            wr(VEC[i][95:64], VEC[i][63:32]);
        end
        for (int i = 0; i < NVEC; i++) begin
            rd(VEC[i][95:64]);
            check("R1 R5 R6 table readback", 64'(cfg_rdata_o), 64'(VEC[i][31:0]));
        end
        check("R2 R5 cb outputs", 64'(cb_sel_o), 64'h37);
        check("R2 R5 sb outputs", 64'(sb_cfg_o), 64'h16);
        check("R2 core outputs", core_cfg_o, 64'h1234_5678_DEAD_BEEF);

        // R3: foreign identifier write ignored
        wr(mk(8'd0, 8'd3, TID + 16'd1), 32'h0);
        wr(mk(8'd0, 8'd0, TID ^ 16'h8000), 32'h2);
        check("R3 core unchanged", core_cfg_o, 64'h1234_5678_DEAD_BEEF);
        check("R3 cb unchanged", 64'(cb_sel_o), 64'h37);

        // R4: missing feature and missing register ignored
        wr(mk(8'd0, 8'd4, TID), 32'hFFFF_FFFF);
        wr(mk(8'd1, 8'd0, TID), 32'h1);
        wr(mk(8'd4, 8'd2, TID), 32'h3);
        wr(mk(8'd2, 8'd3, TID), 32'h5);
        check("R4 cb unchanged", 64'(cb_sel_o), 64'h37);
        check("R4 sb unchanged", 64'(sb_cfg_o), 64'h16);
        check("R4 core unchanged", core_cfg_o, 64'h1234_5678_DEAD_BEEF);

        // R7: misses read zero, each preceded by a non-zero read
        rd(mk(8'd0, 8'd3, TID));
        rd(mk(8'd0, 8'd3, TID + 16'd1));
        check("R7 foreign read", 64'(cfg_rdata_o), 64'h0);
        rd(mk(8'd1, 8'd3, TID));
        rd(mk(8'd0, 8'd7, TID));
        check("R7 missing feature read", 64'(cfg_rdata_o), 64'h0);
        rd(mk(8'd1, 8'd3, TID));
        rd(mk(8'd5, 8'd2, TID));
        check("R7 missing register read", 64'(cfg_rdata_o), 64'h0);
        rd(mk(8'd0, 8'd3, TID));
        rd(mk(8'd1, 8'd1, TID));
        check("R7 missing cb register read", 64'(cfg_rdata_o), 64'h0);

        // R8: read data holds while the address moves without a strobe
        rd(mk(8'd0, 8'd3, TID));
        cfg_addr_i = mk(8'd1, 8'd3, TID);
        repeat (3) @(negedge clk);
        check("R8 rdata held", 64'(cfg_rdata_o), 64'hDEAD_BEEF);

        // R11: read and write of the same register in one cycle
        cfg_addr_i  = mk(8'd1, 8'd3, TID);
        cfg_wdata_i = 32'hCAFE_F00D;
        cfg_we_i    = 1'b1;
        cfg_re_i    = 1'b1;
        @(negedge clk);
        cfg_we_i = 1'b0;
        cfg_re_i = 1'b0;
        check("R11 old value read", 64'(cfg_rdata_o), 64'h1234_5678);
        rd(mk(8'd1, 8'd3, TID));
        check("R11 new value after", 64'(cfg_rdata_o), 64'hCAFE_F00D);

        // R10: identifier port is live
        tile_id_i = TID2;
        @(negedge clk);
        wr(mk(8'd0, 8'd0, TID), 32'h1);
        check("R10 old id ignored", 64'(cb_sel_o), 64'h37);
        wr(mk(8'd0, 8'd0, TID2), 32'h5);
        check("R10 new id accepted", 64'(cb_sel_o), 64'h35);
        rd(mk(8'd0, 8'd0, TID2));
        check("R10 new id read", 64'(cfg_rdata_o), 64'h5);

        // R9: reset again mid-run
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R9 cb after re-reset", 64'(cb_sel_o), 64'h99);
        check("R9 core after re-reset", core_cfg_o, 64'h0);
        check("R9 rdata after re-reset", 64'(cfg_rdata_o), 64'h0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule